// File: doc/BRIEF.md
# Serial Memory Command Sequencer

This block turns single-byte host requests into the complete command frames that a byte-addressed serial nonvolatile memory expects. It runs on top of a byte engine that moves one byte per request over a serial link and owns the serial clock and the chip-select pin. The sequencer chooses each byte to send and tells the engine whether chip select must stay low after that byte. A host raises `req_valid` with a 16-bit address, a direction bit and, for a store, a data byte. The sequencer then walks the frames and ends with a one-cycle `done`.

A load is a single frame: the read command, the address with the high byte first, then a filler byte whose reply becomes `rd_data`. A store takes two frames. The first frame is a lone write-enable command, and chip select is released after it. After a programmable quiet time the second frame carries the write command, the address and the data byte. The block accepts work only while idle and shows `busy` for the whole operation.

Top module: `nvm_cmd_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, `busy`, `done` and `eng_start` are low and `rd_data` is 0x00.
- R2: A load (`req_write`=0) produces exactly one frame of four bytes: 0x03, address bits 15:8, address bits 7:0, then the filler 0x00.
- R3: A store (`req_write`=1) produces a one-byte frame holding 0x06, then a four-byte frame of 0x02, address bits 15:8, address bits 7:0 and the data byte.
- R4: `eng_hold` is 1 with every byte of a frame except the last, where it is 0.
- R5: Between the `eng_done` that closes the write-enable frame and the `eng_start` that opens the write frame there are exactly GAP_CYCLES clock cycles, and no start is issued in them.
- R6: `eng_start` is a one-cycle pulse, and no new start is issued until `eng_done` has answered the previous one.
- R7: `done` is high for exactly one cycle, the cycle after the `eng_done` of the last byte of the last frame. A load places the engine's reply to the filler byte on `rd_data` in that cycle. `rd_data` keeps its value until the next load completes, and a store leaves it unchanged.
- R8: `busy` rises the cycle after a request is accepted in idle, stays high through the `done` cycle and is low in the next cycle.
- R9: `req_valid` has no effect while `busy` is high. No extra frame follows, and the memory content at that address is unchanged.
- R10: `eng_done` has no effect while the block is idle. No start is issued, `busy` and `done` stay low, and `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Memory byte address |
| req_wdata | input | 8 | Byte to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Byte returned by the last load |
| eng_start | output | 1 | Ask the byte engine to move one byte |
| eng_tx | output | 8 | Byte for the engine to send |
| eng_hold | output | 1 | Keep chip select low after this byte |
| eng_done | input | 1 | Engine finished the current byte |
| eng_rx | input | 8 | Byte the engine received |

## Verification
The hardest conditions to reach from the ports are a request that arrives in the middle of an operation and a reset that cuts a store between its enable frame and its write frame. The bench reaches the first by raising `req_valid` with a store a few cycles into a load. It then reads that address back to show the memory is untouched. For the second, it asserts reset a few cycles into a store and then loads the same address, expecting the old content. The behavioural engine also raises `eng_done` on its own while the block is idle, to show that a stray completion is ignored.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] FILL_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP,
    ST_FIN
  } seq_state_t;

  typedef enum logic {
    FR_ENABLE,
    FR_MAIN
  } frame_t;

  // Number of bytes in a frame: enable frame is the opcode only,
  // main frame is opcode + address bytes + one data byte.
  function automatic int frame_len(frame_t f, int addr_bytes);
    return (f == FR_ENABLE) ? 1 : addr_bytes + 2;
  endfunction

  // Position of address byte k (0 = first sent) within the address word,
  // most significant byte first.
  function automatic int addr_byte_lsb(int k, int addr_bytes);
    return 8 * (addr_bytes - 1 - k);
  endfunction

endpackage

// File: rtl/nvm_seq_bytegen.sv
module nvm_seq_bytegen
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 2
) (
  input  frame_t              frame,
  input  logic                is_write,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [STEP_W-1:0]   step,
  output logic [7:0]          tx_byte,
  output logic                last_byte
);

  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [7:0] abyte [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign abyte[g] = addr[addr_byte_lsb(g, ADDR_BYTES) +: 8];
  end

  always_comb begin
    tx_byte = FILL_BYTE;
    if (frame == FR_ENABLE) begin
      tx_byte = OP_WREN;
    end else if (step == '0) begin
      tx_byte = is_write ? OP_WRITE : OP_READ;
    end else if (int'(step) > ADDR_BYTES) begin
      tx_byte = is_write ? wdata : FILL_BYTE;
    end else begin
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (int'(step) == k + 1) tx_byte = abyte[k];
      end
    end
  end

  assign last_byte = (int'(step) == frame_len(frame, ADDR_BYTES) - 1);

endmodule

// File: rtl/nvm_seq_gap_timer.sv
module nvm_seq_gap_timer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= RELOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx,
  input  logic              frame_last,
  input  logic              gap_expired,
  output seq_state_t        state,
  output frame_t            frame,
  output logic [STEP_W-1:0] step,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  output logic              gap_load,
  output logic              rd_capture
);

  logic byte_closed;

  assign byte_closed = (state == ST_WAIT) && eng_done;
  assign gap_load    = byte_closed && frame_last && (frame == FR_ENABLE);
  assign rd_capture  = byte_closed && frame_last && (frame == FR_MAIN) && !is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frame    <= FR_MAIN;
      step     <= '0;
      is_write <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      rd_data  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            is_write <= req_write;
            addr     <= req_addr;
            wdata    <= req_wdata;
            frame    <= req_write ? FR_ENABLE : FR_MAIN;
            step     <= '0;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (eng_done) begin
            if (!frame_last) begin
              step  <= step + 1'b1;
              state <= ST_ISSUE;
            end else if (frame == FR_ENABLE) begin
              state <= ST_GAP;
            end else begin
              if (rd_capture) rd_data <= eng_rx;
              state <= ST_FIN;
            end
          end
        end
        ST_GAP: begin
          if (gap_expired) begin
            frame <= FR_MAIN;
            step  <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  output logic              eng_hold,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int MAIN_LEN   = ADDR_BYTES + 2;
  localparam int STEP_W     = $clog2(MAIN_LEN);

  seq_state_t        state;
  frame_t            frame;
  logic [STEP_W-1:0] step;
  logic              is_write;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata;
  logic              frame_last;
  logic              gap_expired;
  logic              gap_load;
  logic              rd_capture;

  // Named internal events for the checker.
  logic in_gap;

  nvm_seq_ctrl #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .eng_done   (eng_done),
    .eng_rx     (eng_rx),
    .frame_last (frame_last),
    .gap_expired(gap_expired),
    .state      (state),
    .frame      (frame),
    .step       (step),
    .is_write   (is_write),
    .addr       (addr),
    .wdata      (wdata),
    .rd_data    (rd_data),
    .gap_load   (gap_load),
    .rd_capture (rd_capture)
  );

  nvm_seq_bytegen #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_bytegen (
    .frame    (frame),
    .is_write (is_write),
    .addr     (addr),
    .wdata    (wdata),
    .step     (step),
    .tx_byte  (eng_tx),
    .last_byte(frame_last)
  );

  nvm_seq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (gap_load),
    .expired(gap_expired)
  );

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign eng_start = (state == ST_ISSUE);
  assign eng_hold  = !frame_last;
  assign in_gap    = (state == ST_GAP);

endmodule

// File: rtl/nvm_cmd_seq_chk.sv
module nvm_cmd_seq_chk #(
  parameter int GAP_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       eng_start,
  input logic [7:0] eng_tx,
  input logic       eng_hold,
  input logic       eng_done,
  input logic       in_gap
);

  logic outstanding;
  logic first_byte;
  logic cur_hold;
  int   gap_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      first_byte  <= 1'b1;
      cur_hold    <= 1'b0;
      gap_len     <= 0;
    end else begin
      if (eng_start) begin
        outstanding <= 1'b1;
        cur_hold    <= eng_hold;
        first_byte  <= 1'b0;
      end else if (eng_done && outstanding) begin
        outstanding <= 1'b0;
        first_byte  <= !cur_hold;
      end
      gap_len <= in_gap ? gap_len + 1 : 0;
    end
  end

  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !outstanding);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(eng_done));

  a_r2_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && first_byte) |-> (eng_tx == 8'h06 || eng_tx == 8'h02 || eng_tx == 8'h03));

  a_r3_enable_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && first_byte && eng_tx == 8'h06) |-> !eng_hold);

  a_r5_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> !eng_start);

  a_r5_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_gap) |-> (gap_len == GAP_CYCLES));

endmodule

bind nvm_cmd_seq nvm_cmd_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .eng_start(eng_start),
  .eng_tx   (eng_tx),
  .eng_hold (eng_hold),
  .eng_done (eng_done),
  .in_gap   (in_gap)
);

// File: tb/nvm_cmd_seq_test.sv
`timescale 1ns/1ps
module nvm_cmd_seq_test;

  localparam int GAP = 4;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, done, eng_start, eng_hold, eng_done;
  logic [7:0]  rd_data, eng_tx, eng_rx;

  always #4 clk = ~clk;

  nvm_cmd_seq #(.ADDR_W(16), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .eng_start(eng_start), .eng_tx(eng_tx),
    .eng_hold(eng_hold), .eng_done(eng_done), .eng_rx(eng_rx)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural byte engine and memory ----------------
  logic [7:0] mdl_mem [256];
  logic [7:0] log_tx   [16];
  logic       log_hold [16];
  int         log_gap  [16];
  int         log_n = 0;
  int         proto_err = 0;
  bit         inject_done = 0;

  bit         pend = 0, wel = 0, frame_closed = 1, cur_hold = 0;
  int         lat = 0, gap_count = 0, bidx = 0;
  logic [7:0] cur_tx, op, alo;

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mdl_mem[i] = init_val(i);
    eng_done = 0;
    eng_rx   = 0;
    op = 0; alo = 0; cur_tx = 0;
    forever begin
      @(negedge clk);
      eng_done = 0;
      if (!rst_n) begin
        pend = 0; bidx = 0; wel = 0; frame_closed = 1; gap_count = 0;
        continue;
      end
      if (inject_done) begin
        eng_done = 1; eng_rx = 8'hEE;
      end
      if (pend) begin
        if (eng_start) proto_err++;
        if (lat == 0) begin
          eng_rx = 8'hFF;
          if (bidx == 0) op = cur_tx;
          if (bidx == 2) alo = cur_tx;
          if (bidx == 3 && op == 8'h03) eng_rx = mdl_mem[alo];
          if (bidx == 3 && op == 8'h02 && wel) begin
            mdl_mem[alo] = cur_tx; wel = 0;
          end
          if (bidx == 0 && !cur_hold && cur_tx == 8'h06) wel = 1;
          bidx = cur_hold ? bidx + 1 : 0;
          eng_done = 1;
          pend = 0;
          if (!cur_hold) begin frame_closed = 1; gap_count = 0; end
        end else lat--;
      end else if (eng_start) begin
        if (log_n < 16) begin
          log_tx[log_n]   = eng_tx;
          log_hold[log_n] = eng_hold;
          log_gap[log_n]  = frame_closed ? gap_count : -1;
        end
        log_n++;
        cur_tx = eng_tx; cur_hold = eng_hold;
        frame_closed = 0; pend = 1; lat = LAT - 1;
      end else if (frame_closed) gap_count++;
    end
  end

  // ---------------- expectations ----------------
  logic [7:0] exp_mem [256];
  logic [7:0] last_rd = 8'h00;

  // {write, addr[15:0], data[7:0]}
  localparam logic [24:0] VEC [9] = '{
    {1'b1, 16'h1234, 8'h5A},
    {1'b0, 16'h1234, 8'h00},
    {1'b1, 16'hABCD, 8'h00},
    {1'b0, 16'hABCD, 8'h00},
    {1'b0, 16'h0077, 8'h00},
    {1'b1, 16'hFF80, 8'hFF},
    {1'b0, 16'hFF80, 8'h00},
    {1'b1, 16'h1234, 8'hC3},
    {1'b0, 16'h1234, 8'h00}
  };

  task automatic check_frames(input logic wr, input logic [15:0] a, input logic [7:0] d);
    if (wr) begin
      check(log_n == 5, "R3 store byte count", log_n, 5);
      check(log_tx[0] == 8'h06, "R3 enable opcode", log_tx[0], 8'h06);
      check(log_hold[0] == 1'b0, "R4 enable frame closes", log_hold[0], 0);
      check(log_tx[1] == 8'h02 && log_tx[2] == a[15:8] && log_tx[3] == a[7:0] && log_tx[4] == d,
            "R3 write frame bytes", {log_tx[1], log_tx[2], log_tx[3], log_tx[4]}, {8'h02, a, d});
      check(log_hold[1] && log_hold[2] && log_hold[3] && !log_hold[4],
            "R4 write frame hold", {log_hold[1], log_hold[2], log_hold[3], log_hold[4]}, 4'b1110);
      check(log_gap[1] == GAP, "R5 quiet cycles", log_gap[1], GAP);
    end else begin
      check(log_n == 4, "R2 load byte count", log_n, 4);
      check(log_tx[0] == 8'h03 && log_tx[1] == a[15:8] && log_tx[2] == a[7:0] && log_tx[3] == 8'h00,
            "R2 load frame bytes", {log_tx[0], log_tx[1], log_tx[2], log_tx[3]}, {8'h03, a, 8'h00});
      check(log_hold[0] && log_hold[1] && log_hold[2] && !log_hold[3],
            "R4 load frame hold", {log_hold[0], log_hold[1], log_hold[2], log_hold[3]}, 4'b1110);
    end
  endtask

  // Called at a negedge. poke=1 raises a stray store request mid-operation.
  task automatic run_txn(input logic wr, input logic [15:0] a, input logic [7:0] d, input bit poke);
    int  cyc = 0;
    bit  dropped = 0;
    log_n = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    while (!done && cyc < 200) begin
      if (!busy) dropped = 1;
      if (poke && cyc == 3) begin
        req_valid = 1; req_write = 1; req_addr = 16'h00C3; req_wdata = 8'h99;
      end
      if (poke && cyc == 5) req_valid = 0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 0;
    check(done == 1'b1, "R7 done seen", done, 1);
    check(!dropped, "R8 busy held", dropped, 0);
    if (wr) exp_mem[a[7:0]] = d;
    else last_rd = exp_mem[a[7:0]];
    check(rd_data == last_rd, wr ? "R7 store keeps rd_data" : "R7 load result", rd_data, last_rd);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 R8 done one cycle, busy low", {done, busy}, 0);
    check_frames(wr, a, d);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && eng_start == 0 && rd_data == 0, "R1 reset state",
          {busy, done, eng_start, rd_data}, 0);
    rst_n = 1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      run_txn(VEC[i][24], VEC[i][23:8], VEC[i][7:0], 0);
      @(negedge clk);
    end

    // R9: request while busy is ignored
    run_txn(1'b0, 16'h4410, 8'h00, 1);
    log_n = 0;
    repeat (20) @(negedge clk);
    check(log_n == 0 && busy == 0, "R9 no frame after stray request", log_n, 0);
    run_txn(1'b0, 16'h00C3, 8'h00, 0);
    check(rd_data == init_val(8'hC3), "R9 memory untouched", rd_data, init_val(8'hC3));
    @(negedge clk);

    // R10: engine completion while idle is ignored
    log_n = 0;
    inject_done = 1;
    @(negedge clk);
    inject_done = 0;
    repeat (3) begin
      @(negedge clk);
      check(busy == 0 && done == 0 && log_n == 0, "R10 idle ignores eng_done",
            {busy, done, 8'(log_n)}, 0);
    end
    check(rd_data == last_rd, "R10 rd_data kept", rd_data, last_rd);

    // R1: reset cuts a store before the write frame
    req_valid = 1; req_write = 1; req_addr = 16'h2211; req_wdata = 8'h42;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(busy == 0 && done == 0 && eng_start == 0 && rd_data == 0, "R1 reset mid-operation",
          {busy, done, eng_start, rd_data}, 0);
    rst_n = 1;
    last_rd = 8'h00;
    repeat (2) @(negedge clk);
    run_txn(1'b0, 16'h2211, 8'h00, 0);
    check(rd_data == init_val(8'h11), "R1 aborted store not committed", rd_data, init_val(8'h11));

    check(proto_err == 0, "R6 start while byte pending", proto_err, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R6 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule